// File: doc/BRIEF.md
# External Edge Counter with Compare Output

This block counts transitions of an asynchronous external signal instead of system clock cycles. The signal first passes through a two-flop synchronizer. A selectable edge mode then decides which transitions advance a 16-bit count: rising, falling, both, or none. When the count passes its top value it does not wrap to zero. It restarts from a programmable reload value and raises a sticky overflow flag.

A compare register is checked against every new count value. A hit raises a sticky compare flag. A hit is only possible for compare values that lie inside the reachable range, which runs from the reload value up to the top value. The two flags are combined with an interrupt enable to form one interrupt request. Software clears each flag with its own strobe.

A waveform register sits behind the output pin. A compare hit toggles it. An overflow returns it to a starting level that is latched from the polarity input only when the output enable goes from 0 to 1. The pin is held low while the output is disabled.

Top module: `edge_count_cmp`

## Requirements
- R1: With `edge_sel` = 01 each rising input edge adds one to `count`. With 10 each falling edge adds one. With 11 every edge adds one. A change on `ext_in` shows on `count` at the third rising clock edge after it.
- R2: With `edge_sel` = 00 no input transition changes `count`.
- R3: At most one count step is taken per clock cycle. A one-cycle input pulse in both-edge mode therefore counts as two separate steps.
- R4: A counted edge while `count` holds its top value (all ones) loads `reload_val` into `count` and sets `ovf_flag`.
- R5: When a counted edge makes the new count equal `cmp_val`, `cmp_flag` is set, provided `cmp_val` >= `reload_val`. This includes the case where the new count is the reloaded value.
- R6: While `cmp_val` < `reload_val`, `cmp_flag` is never set.
- R7: A one-cycle pulse on `clr_ovf` clears `ovf_flag`, and a pulse on `clr_cmp` clears `cmp_flag`. A set event in the same cycle as a clear leaves the flag set.
- R8: `irq` is 1 exactly when `irq_en` is 1 and at least one of `ovf_flag` or `cmp_flag` is 1.
- R9: `pin_out` is 0 whenever `out_en` is 0.
- R10: On a 0-to-1 change of `out_en` the waveform level becomes `out_pol`, and that value is latched as the starting level. A change of `out_pol` at any other time does not reach `pin_out`.
- R11: A compare hit inverts the waveform level. An overflow returns it to the latched starting level. If both happen on the same step, the overflow wins.
- R12: After reset `count`, `ovf_flag`, `cmp_flag`, `irq` and `pin_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | Asynchronous external signal whose edges are counted |
| edge_sel | input | 2 | Counted edges: 00 none, 01 rising, 10 falling, 11 both |
| reload_val | input | 16 | Value loaded into the count on overflow |
| cmp_val | input | 16 | Compare value |
| out_en | input | 1 | Output pin enable |
| out_pol | input | 1 | Starting level of the waveform, taken on an out_en rise |
| irq_en | input | 1 | Interrupt enable |
| clr_ovf | input | 1 | Clear strobe for the overflow flag |
| clr_cmp | input | 1 | Clear strobe for the compare flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Output pin level |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in the same clock cycle as an overflow. The overflow happens only after the synchronizer delay, and only once the count has been walked to its top value. The bench uses a 4-bit configuration so the top value is reached quickly. It drives the edge that causes the overflow on a falling clock edge and places the clear pulse exactly two falling clock edges later, so that both meet at the same rising clock edge. The same small width allows a full sweep of every reload and compare pair in both-edge mode, with the count, both flags, the interrupt and the pin predicted arithmetically.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/ecc_sync.sv
module ecc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], async_in};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sh[STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.sh[STAGES-1] & st_q.prev;
endmodule

// File: rtl/ecc_core.sv
module ecc_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    input  logic [W-1:0] cmp_val,
    input  logic         clr_ovf,
    input  logic         clr_cmp,
    output logic [W-1:0] count,
    output logic         ovf_evt,
    output logic         match_evt,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
        logic         cmp;
    } core_t;

    core_t        st_d, st_q;
    logic [W-1:0] nxt_cnt;

    always_comb begin
        st_d      = st_q;
        ovf_evt   = step && (st_q.cnt == TOP);
        nxt_cnt   = ovf_evt ? reload_val : st_q.cnt + ONE;
        match_evt = step && (cmp_val >= reload_val) && (nxt_cnt == cmp_val);
        if (step) st_d.cnt = nxt_cnt;
        st_d.ovf = ovf_evt   | (st_q.ovf & ~clr_ovf);
        st_d.cmp = match_evt | (st_q.cmp & ~clr_cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign ovf_flag = st_q.ovf;
    assign cmp_flag = st_q.cmp;

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == TOP) |=> (count == $past(reload_val)));
    a_r6_no_low_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val < reload_val && !cmp_flag) |=> !cmp_flag);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == TOP && clr_ovf) |=> ovf_flag);
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + ONE
                  || count == $past(reload_val)));
endmodule

// File: rtl/ecc_wave.sv
module ecc_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic out_pol,
    input  logic ovf_evt,
    input  logic match_evt,
    output logic pin_out
);
    typedef struct packed {
        logic wave;
        logic pol_lat;
        logic oen_prev;
    } wave_t;

    wave_t st_d, st_q;
    logic  en_rise;

    always_comb begin
        st_d          = st_q;
        en_rise       = out_en & ~st_q.oen_prev;
        st_d.oen_prev = out_en;
        if (en_rise) begin
            st_d.wave    = out_pol;
            st_d.pol_lat = out_pol;
        end else if (ovf_evt) begin
            st_d.wave = st_q.pol_lat;
        end else if (match_evt) begin
            st_d.wave = ~st_q.wave;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out = out_en & st_q.wave;

    a_r10_pol_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !st_q.oen_prev) |=> (st_q.wave == $past(out_pol)));
    a_r10_pol_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oen_prev && out_en && !ovf_evt && !match_evt) |=> $stable(st_q.wave));
endmodule

// File: rtl/edge_count_cmp.sv
module edge_count_cmp #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_in,
    input  logic [1:0]       edge_sel,
    input  logic [WIDTH-1:0] reload_val,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic             out_en,
    input  logic             out_pol,
    input  logic             irq_en,
    input  logic             clr_ovf,
    input  logic             clr_cmp,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             irq,
    output logic             pin_out
);
    import ecc_pkg::*;

    edge_mode_e mode;
    logic       rise, fall, step, ovf_evt, match_evt;

    assign mode = edge_mode_e'(edge_sel);

    ecc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_in), .rise(rise), .fall(fall)
    );

    always_comb begin
        unique case (mode)
            SEL_RISE: step = rise;
            SEL_FALL: step = fall;
            SEL_BOTH: step = rise | fall;
            default:  step = 1'b0;
        endcase
    end

    ecc_core #(.W(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step),
        .reload_val(reload_val), .cmp_val(cmp_val),
        .clr_ovf(clr_ovf), .clr_cmp(clr_cmp),
        .count(count), .ovf_evt(ovf_evt), .match_evt(match_evt),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    ecc_wave u_wave (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .out_pol(out_pol),
        .ovf_evt(ovf_evt), .match_evt(match_evt), .pin_out(pin_out)
    );

    assign irq = irq_en & (ovf_flag | cmp_flag);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |=> $stable(count));
endmodule

// File: tb/edge_count_cmp_tb.sv
`timescale 1ns/1ps
module edge_count_cmp_tb;
    localparam int W   = 4;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_in = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic [W-1:0] reload_val = '0;
    logic [W-1:0] cmp_val = '1;
    logic         out_en = 1'b0, out_pol = 1'b0, irq_en = 1'b0;
    logic         clr_ovf = 1'b0, clr_cmp = 1'b0;
    logic [W-1:0] count;
    logic         ovf_flag, cmp_flag, irq, pin_out;

    int checks = 0, errors = 0;
    int m_cnt, m_ovf, m_cmp, m_wave, m_pol;

    always #4 clk = ~clk;

    edge_count_cmp #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .edge_sel(edge_sel),
        .reload_val(reload_val), .cmp_val(cmp_val), .out_en(out_en),
        .out_pol(out_pol), .irq_en(irq_en), .clr_ovf(clr_ovf), .clr_cmp(clr_cmp),
        .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .irq(irq), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        ext_in = 1'b0; clr_ovf = 1'b0; clr_cmp = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_cnt = 0; m_ovf = 0; m_cmp = 0; m_wave = 0; m_pol = 0;
        if (out_en) begin m_wave = out_pol; m_pol = out_pol; end
    endtask

    // model of one counted edge (R1, R4, R5, R6, R11)
    task automatic model_step();
        if (m_cnt == TOP) begin
            m_cnt = reload_val; m_ovf = 1; m_wave = m_pol;
            if (cmp_val == reload_val) m_cmp = 1;
        end else begin
            m_cnt++;
            if (cmp_val >= reload_val && m_cnt == cmp_val) begin
                m_cmp = 1; m_wave ^= 1;
            end
        end
    endtask

    task automatic toggle();
        ext_in = ~ext_in;
        repeat (4) @(negedge clk);
        if ((edge_sel == 2'b01 && ext_in) || (edge_sel == 2'b10 && !ext_in) ||
            edge_sel == 2'b11)
            model_step();
    endtask

    task automatic check_all();
        chk("R4 count", count, m_cnt);
        chk("R4 ovf_flag", ovf_flag, m_ovf);
        chk(cmp_val < reload_val ? "R6 cmp_flag" : "R5 cmp_flag", cmp_flag, m_cmp);
        chk("R8 irq", irq, irq_en && (m_ovf || m_cmp));
        chk("R11 pin_out", pin_out, out_en ? m_wave : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset();
        chk("R12 count", count, 0);
        chk("R12 ovf_flag", ovf_flag, 0);
        chk("R12 cmp_flag", cmp_flag, 0);
        chk("R12 irq", irq, 0);
        chk("R12 pin_out", pin_out, 0);

        // R1 / R2: every edge mode
        for (int s = 0; s < 4; s++) begin
            edge_sel = 2'(s);
            do_reset();
            for (int k = 0; k < 8; k++) begin
                toggle();
                chk(s == 0 ? "R2 hold" : "R1 edge count", count, m_cnt);
            end
        end

        // R3: one-cycle pulse in both-edge mode gives two steps
        edge_sel = 2'b11;
        do_reset();
        ext_in = 1'b1; @(negedge clk); ext_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 short pulse", count, 2);

        // sweep of reload and compare in both-edge mode
        out_en = 1'b1;
        for (int r = 0; r <= TOP; r++) begin
            for (int c = 0; c <= TOP; c++) begin
                reload_val = W'(r); cmp_val = W'(c);
                out_pol = r[0]; irq_en = c[0];
                do_reset();
                for (int k = 0; k < 40; k++) begin
                    toggle();
                    check_all();
                end
            end
        end

        // R7: clears and set-wins collision
        out_en = 1'b0; irq_en = 1'b1; edge_sel = 2'b01;
        reload_val = '0; cmp_val = W'(3);
        do_reset();
        repeat (34) toggle();
        chk("R7 ovf before clear", ovf_flag, 1);
        chk("R7 cmp before clear", cmp_flag, 1);
        clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0; @(negedge clk);
        m_ovf = 0;
        chk("R7 ovf cleared", ovf_flag, 0);
        chk("R7 cmp kept", cmp_flag, 1);
        chk("R8 irq from cmp", irq, 1);
        clr_cmp = 1'b1; @(negedge clk); clr_cmp = 1'b0; @(negedge clk);
        m_cmp = 0;
        chk("R7 cmp cleared", cmp_flag, 0);
        chk("R8 irq low", irq, 0);
        while (!(m_cnt == TOP && ext_in == 1'b0)) toggle();
        ext_in = 1'b1;
        @(negedge clk); @(negedge clk);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        @(negedge clk);
        model_step();
        chk("R7 set wins", ovf_flag, 1);
        chk("R4 reload after wrap", count, m_cnt);

        // R9 / R10: enable and polarity
        out_en = 1'b0; out_pol = 1'b1; edge_sel = 2'b00;
        do_reset();
        chk("R9 disabled pin", pin_out, 0);
        out_en = 1'b1; repeat (2) @(negedge clk);
        chk("R10 pol on enable", pin_out, 1);
        out_pol = 1'b0; repeat (3) @(negedge clk);
        chk("R10 pol ignored while enabled", pin_out, 1);
        out_en = 1'b0; repeat (2) @(negedge clk);
        chk("R9 disabled again", pin_out, 0);
        out_en = 1'b1; repeat (2) @(negedge clk);
        chk("R10 new pol on re-enable", pin_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule